// File: doc/BRIEF.md
# Register Rename Map with Free Tag Queue

This block is the rename stage of an out-of-order core that keeps all results in one physical register file indexed by tag. Each cycle the front end offers one instruction. Its two source registers are translated through a map table, indexed by architectural register number, into physical tags. An instruction that writes a register takes the oldest tag from a queue of free physical tags, and the map entry for its destination is updated to that tag. The tag the destination held before the update travels with the instruction into an in-order retirement queue.

When the oldest instruction graduates, the back end pulses `grad_en`. The displaced tag saved in that record then goes back to the tail of the free queue. A tag can therefore be reused only after every reader of the older value has graduated. The front end is held off when a destination needs a tag and none is free, or when the retirement queue is full.

Top module: `reg_rename_map`

## Requirements
- R1: After reset, architectural register i maps to physical tag i. The free queue holds tags ARCH_REGS up to PHYS_REGS-1, in ascending order, with the lowest at its head. The retirement queue is empty, so `grad_valid` is 0.
- R2: `out_src_a_tag` and `out_src_b_tag` give the current mapping of `in_src_a` and `in_src_b` combinationally, whether `in_valid` is high or low.
- R3: An accepted instruction (`in_valid` and `in_ready`) with `in_has_dst`=1 is given the head of the free queue on `out_dst_tag`. From the next cycle, that tag is the mapping of `in_dst`.
- R4: Instructions accepted later that read `in_dst` see the new tag.
- R5: `out_old_tag` shows the mapping `in_dst` held before the update. A source that names the same register as the destination reads that earlier mapping, not the new tag.
- R6: Every accepted instruction adds one record to the retirement queue, in program order. `grad_valid` is high while the queue is non-empty. `grad_has_dst` and `grad_old_tag` describe the oldest record. `grad_en` removes that record, and has no effect while the queue is empty.
- R7: Graduating a record with a destination appends its saved old tag to the tail of the free queue. Tags leave the free queue in the order they entered it.
- R8: An instruction with `in_has_dst`=0 takes no free tag and leaves the map unchanged. Its graduation returns no tag.
- R9: `in_ready` is low when `in_has_dst`=1 and the free queue is empty. A tag returned by a graduation in the same cycle does not lift the stall. An instruction without a destination is still accepted while the free queue is empty.
- R10: `in_ready` is low whenever the retirement queue holds ROB_DEPTH records.
- R11: An instruction that is offered but not accepted changes neither the map, the free queue nor the retirement queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered for renaming |
| in_ready | output | 1 | Instruction can be accepted this cycle |
| in_src_a | input | $clog2(ARCH_REGS) | First source architectural register |
| in_src_b | input | $clog2(ARCH_REGS) | Second source architectural register |
| in_has_dst | input | 1 | Instruction writes a register |
| in_dst | input | $clog2(ARCH_REGS) | Destination architectural register |
| out_src_a_tag | output | $clog2(PHYS_REGS) | Physical tag of first source |
| out_src_b_tag | output | $clog2(PHYS_REGS) | Physical tag of second source |
| out_dst_tag | output | $clog2(PHYS_REGS) | Fresh tag for the destination |
| out_old_tag | output | $clog2(PHYS_REGS) | Displaced previous tag of the destination |
| grad_en | input | 1 | Graduate the oldest record |
| grad_valid | output | 1 | Retirement queue is non-empty |
| grad_has_dst | output | 1 | Oldest record wrote a register |
| grad_old_tag | output | $clog2(PHYS_REGS) | Tag the oldest record returns on graduation |

## Verification
A corrupted map entry shows up on the source tag outputs in the very cycle that register is read. It also shows up one graduation later, as a wrong displaced tag. A lost or duplicated free-queue entry stays hidden until that entry reaches the head. It then appears as a wrong `out_dst_tag`, or as an early or missing stall, after at most PHYS_REGS-ARCH_REGS renames. The bench therefore runs a small configuration in which the free queue wraps many times. It compares every tag and every ready decision, cycle by cycle, against an arithmetic model.

// File: rtl/reg_rename_map.sv
module reg_rename_map #(
  parameter int ARCH_REGS = 32,
  parameter int PHYS_REGS = 80,
  parameter int ROB_DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [$clog2(ARCH_REGS)-1:0] in_src_a,
  input  logic [$clog2(ARCH_REGS)-1:0] in_src_b,
  input  logic                         in_has_dst,
  input  logic [$clog2(ARCH_REGS)-1:0] in_dst,
  output logic [$clog2(PHYS_REGS)-1:0] out_src_a_tag,
  output logic [$clog2(PHYS_REGS)-1:0] out_src_b_tag,
  output logic [$clog2(PHYS_REGS)-1:0] out_dst_tag,
  output logic [$clog2(PHYS_REGS)-1:0] out_old_tag,
  input  logic                         grad_en,
  output logic                         grad_valid,
  output logic                         grad_has_dst,
  output logic [$clog2(PHYS_REGS)-1:0] grad_old_tag
);
  localparam int PW    = $clog2(PHYS_REGS);
  localparam int FREE  = PHYS_REGS - ARCH_REGS;
  localparam int FPW   = $clog2(FREE);
  localparam int FCW   = $clog2(FREE + 1);
  localparam int RPW   = $clog2(ROB_DEPTH);
  localparam int RCW   = $clog2(ROB_DEPTH + 1);

  logic [ARCH_REGS-1:0][PW-1:0] map_q;
  logic [PW-1:0]  free_mem [FREE];
  logic [FPW-1:0] free_rd, free_wr;
  logic [FCW-1:0] free_cnt;
  logic [PW:0]    rob_mem  [ROB_DEPTH];
  logic [RPW-1:0] rob_rd, rob_wr;
  logic [RCW-1:0] rob_cnt;

  logic fire, take, grad_fire, give_back;

  assign in_ready  = (rob_cnt != RCW'(ROB_DEPTH)) && !(in_has_dst && free_cnt == '0);
  assign fire      = in_valid && in_ready;
  assign take      = fire && in_has_dst;
  assign grad_valid   = rob_cnt != '0;
  assign grad_has_dst = rob_mem[rob_rd][PW];
  assign grad_old_tag = rob_mem[rob_rd][PW-1:0];
  assign grad_fire = grad_en && grad_valid;
  assign give_back = grad_fire && grad_has_dst;

  assign out_src_a_tag = map_q[in_src_a];
  assign out_src_b_tag = map_q[in_src_b];
  assign out_old_tag   = map_q[in_dst];
  assign out_dst_tag   = free_mem[free_rd];

  function automatic logic [FPW-1:0] fnext(input logic [FPW-1:0] p);
    return (p == FPW'(FREE - 1)) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [RPW-1:0] rnext(input logic [RPW-1:0] p);
    return (p == RPW'(ROB_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < ARCH_REGS; i++) map_q[i] <= PW'(i);
    end else if (take) begin
      map_q[in_dst] <= out_dst_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < FREE; i++) free_mem[i] <= PW'(ARCH_REGS + i);
      free_rd  <= '0;
      free_wr  <= '0;
      free_cnt <= FCW'(FREE);
    end else begin
      if (take) free_rd <= fnext(free_rd);
      if (give_back) begin
        free_mem[free_wr] <= grad_old_tag;
        free_wr <= fnext(free_wr);
      end
      free_cnt <= free_cnt + FCW'(give_back) - FCW'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (fire) rob_mem[rob_wr] <= {in_has_dst, out_old_tag};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rob_rd  <= '0;
      rob_wr  <= '0;
      rob_cnt <= '0;
    end else begin
      if (fire)      rob_wr <= rnext(rob_wr);
      if (grad_fire) rob_rd <= rnext(rob_rd);
      rob_cnt <= rob_cnt + RCW'(fire) - RCW'(grad_fire);
    end
  end

  assert_free_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= FCW'(FREE));

  assert_rob_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rob_cnt <= RCW'(ROB_DEPTH));

  assert_map_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> map_q[$past(in_dst)] == $past(out_dst_tag));

  assert_stall_no_change_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(map_q));

  assert_nodst_keeps_free_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !in_has_dst && !give_back) |=> $stable(free_cnt));

  assert_empty_grad_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!grad_valid && !fire) |=> !grad_valid);
endmodule

// File: tb/reg_rename_map_tb.sv
module reg_rename_map_tb_top;
  localparam int NA = 4, NP = 8, NR = 8;
  localparam int AW = $clog2(NA), PW = $clog2(NP);

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_has_dst = 0, grad_en = 0;
  logic [AW-1:0] in_src_a = 0, in_src_b = 0, in_dst = 0;
  logic in_ready, grad_valid, grad_has_dst;
  logic [PW-1:0] out_src_a_tag, out_src_b_tag, out_dst_tag, out_old_tag, grad_old_tag;

  reg_rename_map #(.ARCH_REGS(NA), .PHYS_REGS(NP), .ROB_DEPTH(NR)) dut_i (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  int mmap[NA];
  int fq[$];
  int rob_old[$];
  bit rob_hd[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic peek_all(input string req);
    for (int a = 0; a < NA; a++) begin
      for (int b = 0; b < NA; b++) begin
        @(negedge clk);
        in_valid = 0; in_src_a = AW'(a); in_src_b = AW'(b);
        #1;
        chk(out_src_a_tag == PW'(mmap[a]), req, out_src_a_tag, mmap[a]);
        chk(out_src_b_tag == PW'(mmap[b]), req, out_src_b_tag, mmap[b]);
      end
    end
  endtask

  task automatic step(input bit v, input int a, input int b, input bit hd,
                      input int d, input bit g, input string req);
    bit exp_rdy;
    bit gv;
    @(negedge clk);
    in_valid = v; in_src_a = AW'(a); in_src_b = AW'(b);
    in_has_dst = hd; in_dst = AW'(d); grad_en = g;
    #1;
    exp_rdy = (rob_hd.size() < NR) && !(hd && fq.size() == 0);
    chk(in_ready == exp_rdy, {req, " ready"}, in_ready, exp_rdy);
    chk(out_src_a_tag == PW'(mmap[a]), "R2 src_a", out_src_a_tag, mmap[a]);
    chk(out_src_b_tag == PW'(mmap[b]), "R2 src_b", out_src_b_tag, mmap[b]);
    gv = rob_hd.size() > 0;
    chk(grad_valid == gv, "R6 grad_valid", grad_valid, gv);
    if (gv) begin
      chk(grad_has_dst == rob_hd[0], "R6 grad_has_dst", grad_has_dst, rob_hd[0]);
      if (rob_hd[0])
        chk(grad_old_tag == PW'(rob_old[0]), "R7 grad_old_tag", grad_old_tag, rob_old[0]);
    end
    if (v && exp_rdy && hd) begin
      chk(out_dst_tag == PW'(fq[0]), "R3 dst tag", out_dst_tag, fq[0]);
      chk(out_old_tag == PW'(mmap[d]), "R5 old tag", out_old_tag, mmap[d]);
    end
    @(posedge clk);
    if (v && exp_rdy) begin
      rob_hd.push_back(hd);
      rob_old.push_back(mmap[d]);
      if (hd) mmap[d] = fq.pop_front();
    end
    if (g && gv) begin
      if (rob_hd[0]) fq.push_back(rob_old[0]);
      void'(rob_hd.pop_front());
      void'(rob_old.pop_front());
    end
    #1;
    in_valid = 0; grad_en = 0;
  endtask

  bit finished = 0;

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    for (int i = 0; i < NA; i++) mmap[i] = i;
    for (int i = NA; i < NP; i++) fq.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    chk(grad_valid == 0, "R1 grad_valid reset", grad_valid, 0);
    chk(in_ready == 1, "R1 ready reset", in_ready, 1);
    peek_all("R1 identity map");

    // R5 source equal to destination; R3 fresh tags in order; R4 later reads
    for (int r = 0; r < NA; r++) step(1, r, (r + 1) % NA, 1, r, 0, "R3");
    peek_all("R4 new mapping");
    // R9 stall with free queue empty, R11 no effect
    step(1, 0, 1, 1, 2, 0, "R9 dry stall");
    peek_all("R11 map unchanged");
    // R9/R8 no-destination instruction still accepted
    step(1, 3, 2, 0, 0, 0, "R8 nodst accepted");
    peek_all("R8 map unchanged");
    // R9 return in same cycle does not lift stall
    step(1, 0, 0, 1, 1, 1, "R9 same-cycle return");
    // graduate the rest, including the no-dst record
    for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 0, 1, "R7 graduate");
    step(0, 0, 0, 0, 0, 1, "R6 empty grad");
    // R7 recycled tags come back in return order
    for (int r = 0; r < NA; r++) step(1, r, r, 1, (r + 2) % NA, 0, "R7 reuse");
    for (int i = 0; i < NA; i++) step(0, 0, 0, 0, 0, 1, "R7 graduate");
    // R10 fill retirement queue
    for (int i = 0; i < NR; i++) step(1, i % NA, 0, 0, 0, 0, "R10 fill");
    step(1, 1, 2, 0, 3, 0, "R10 full stall");
    step(1, 1, 2, 1, 3, 0, "R10 full stall dst");
    for (int i = 0; i < NR; i++) step(0, 0, 0, 0, 0, 1, "R6 drain");
    // mixed sweep
    seed = 32'h1234_5678;
    for (int n = 0; n < 4000; n++) begin
      seed = seed * 1103515245 + 12345;
      step(seed[16] | seed[17], int'(seed[19:18]), int'(seed[21:20]),
           seed[22] | seed[23], int'(seed[25:24]), seed[26] | (seed[27] & seed[28]),
           "R9 R10 mixed");
    end
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule